// File: doc/BRIEF.md
# LIN-UART Status Flag Unit

This block keeps the eight status flags of a UART that can also run a LIN link. It sits beside the receiver, the transmitter, the autobaud counter and the break detector, and turns their single-cycle event strobes into sticky flags. Software-side read and write strobes for the status register, the receive data register and the transmit data register clear the flags. Every flag updates on the clock edge that follows its event. The unit also compares the bit driven onto the line with the bit sampled back from it while a LIN transmit is in progress. A mismatch means a physical-layer fault, or a second node driving the bus at the same time.

The serial shifters, the baud generator and the autobaud timing logic are outside the block and are seen only as strobes. No data stream passes through the unit, so every pin is a plain control or status signal. There is no valid/ready handshake and no back-pressure. The packed status byte is a registered output that any reader may sample at any time.

Top module: `lin_uart_flags`

## Requirements
- R1: The receive-available flag goes to 1 on the edge after `rx_load` is high. Otherwise, a `rd_rxd` strobe clears it on the next edge.
- R2: The overrun flag is set when `rx_load` arrives while the receive-available flag is already 1 and `rd_rxd` is low in that cycle. A `rd_rxd` strobe clears it.
- R3: An `abd_ovf` strobe sets both the overrun flag and the autobaud flag. An `abd_done` strobe sets only the autobaud flag. A `rd_stat` strobe clears the autobaud flag.
- R4: The framing flag is set by `rx_ferr` and is cleared by `rd_rxd`.
- R5: The line-error flag is set when `bit_mid`, `lin_tx_active` and `txd_bit != rxd_bit` are all true in the same cycle. A mismatch when `bit_mid` or `lin_tx_active` is low is ignored. The flag is cleared by `rd_stat` or by `rd_rxd`.
- R6: The break flag is set by `brk_evt` and is cleared by `rd_stat` or by `rd_rxd`.
- R7: When a set event and a clearing read of a receive-side or line flag fall in the same cycle, the flag ends at 1.
- R8: The transmit-register-empty flag is 1 out of reset. It is cleared by `wr_txd`. It is set by `tx_load` unless `wr_txd` is high in the same cycle.
- R9: The transmitter-empty flag is 1 out of reset. It is cleared by `tx_load`. It is set by `tx_done` unless `tx_load` is high in the same cycle.
- R10: `stat` packs the flags from bit 7 down to bit 0 in this order: receive-available, line-error, overrun, framing, break, transmit-register-empty, transmitter-empty, autobaud. Its reset value is 8'h06.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rx_load | input | 1 | A received byte was placed in the receive data register |
| rx_ferr | input | 1 | The received character had no stop bit |
| abd_done | input | 1 | Autobaud sequence finished |
| abd_ovf | input | 1 | Baud counter overflowed before autobaud ended |
| brk_evt | input | 1 | Break detector reports a break of the required length |
| lin_tx_active | input | 1 | A LIN transmit is in progress |
| bit_mid | input | 1 | Bit-centre sample strobe |
| txd_bit | input | 1 | Bit currently driven onto the line |
| rxd_bit | input | 1 | Bit sampled back from the line |
| wr_txd | input | 1 | Write strobe of the transmit data register |
| tx_load | input | 1 | Transmitter moved the data register into its shifter |
| tx_done | input | 1 | Shifter emptied, last stop bit sent |
| rd_stat | input | 1 | Read strobe of the status register |
| rd_rxd | input | 1 | Read strobe of the receive data register |
| stat | output | 8 | Packed status byte |

## Verification
Directed phases first drive each strobe alone, and then drive each strobe together with its clearing read. Driving them alone shows which flag every event reaches and which read clears it. Driving them together separates set-wins from clear-wins on every flag. A dedicated phase moves the line bits with `bit_mid` and `lin_tx_active` each held low in turn, then with both high. This shows that only an in-window mismatch raises the line-error flag. A long run of random sparse strobes, compared every cycle against a behavioural model, then reaches the overlapping cases: loads against reads, overflow against completion, and transmitter loads against register writes.

// File: rtl/lin_flags_pkg.sv
package lin_flags_pkg;

  typedef struct packed {
    logic rda;
    logic ple;
    logic oe;
    logic fe;
    logic brkd;
    logic tdre;
    logic txe;
    logic atb;
  } lin_stat_t;

  localparam int STAT_W = $bits(lin_stat_t);
  localparam logic [STAT_W-1:0] STAT_RST = 8'h06;

endpackage

// File: rtl/lin_sticky_flag.sv
module lin_sticky_flag #(
  parameter logic RST_VAL  = 1'b0,
  parameter bit   SET_WINS = 1'b1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic set_i,
  input  logic clr_i,
  output logic q_o
);

  logic q_d;

  generate
    if (SET_WINS) begin : g_set_wins
      always_comb begin
        if (set_i)      q_d = 1'b1;
        else if (clr_i) q_d = 1'b0;
        else            q_d = q_o;
      end
    end else begin : g_clr_wins
      always_comb begin
        if (clr_i)      q_d = 1'b0;
        else if (set_i) q_d = 1'b1;
        else            q_d = q_o;
      end
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) q_o <= RST_VAL;
    else        q_o <= q_d;
  end

endmodule

// File: rtl/lin_rx_flags.sv
module lin_rx_flags (
  input  logic clk,
  input  logic rst_n,
  input  logic rx_load,
  input  logic rx_ferr,
  input  logic abd_done,
  input  logic abd_ovf,
  input  logic rd_stat,
  input  logic rd_rxd,
  output logic rda,
  output logic oe,
  output logic fe,
  output logic atb
);

  logic ovr_set;
  logic atb_set;

  // a byte lands on an unread one, unless that one is being read now
  assign ovr_set = (rx_load & rda & ~rd_rxd) | abd_ovf;
  assign atb_set = abd_done | abd_ovf;

  lin_sticky_flag #(.RST_VAL(1'b0), .SET_WINS(1'b1)) u_rda (
    .clk(clk), .rst_n(rst_n), .set_i(rx_load), .clr_i(rd_rxd), .q_o(rda));
  lin_sticky_flag #(.RST_VAL(1'b0), .SET_WINS(1'b1)) u_oe (
    .clk(clk), .rst_n(rst_n), .set_i(ovr_set), .clr_i(rd_rxd), .q_o(oe));
  lin_sticky_flag #(.RST_VAL(1'b0), .SET_WINS(1'b1)) u_fe (
    .clk(clk), .rst_n(rst_n), .set_i(rx_ferr), .clr_i(rd_rxd), .q_o(fe));
  lin_sticky_flag #(.RST_VAL(1'b0), .SET_WINS(1'b1)) u_atb (
    .clk(clk), .rst_n(rst_n), .set_i(atb_set), .clr_i(rd_stat), .q_o(atb));

  p_rda_set_r1: assert property (@(posedge clk) disable iff (!rst_n)
    rx_load |=> rda);
  p_rda_clr_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_rxd && !rx_load) |=> !rda);
  p_ovr_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_load && rda && !rd_rxd) |=> oe);
  p_abd_ovf_r3: assert property (@(posedge clk) disable iff (!rst_n)
    abd_ovf |=> (oe && atb));
  p_fe_set_r4: assert property (@(posedge clk) disable iff (!rst_n)
    rx_ferr |=> fe);

endmodule

// File: rtl/lin_line_flags.sv
module lin_line_flags (
  input  logic clk,
  input  logic rst_n,
  input  logic lin_tx_active,
  input  logic bit_mid,
  input  logic txd_bit,
  input  logic rxd_bit,
  input  logic brk_evt,
  input  logic rd_stat,
  input  logic rd_rxd,
  output logic ple,
  output logic brkd
);

  logic mismatch;
  logic any_rd;

  assign mismatch = lin_tx_active & bit_mid & (txd_bit ^ rxd_bit);
  assign any_rd   = rd_stat | rd_rxd;

  lin_sticky_flag #(.RST_VAL(1'b0), .SET_WINS(1'b1)) u_ple (
    .clk(clk), .rst_n(rst_n), .set_i(mismatch), .clr_i(any_rd), .q_o(ple));
  lin_sticky_flag #(.RST_VAL(1'b0), .SET_WINS(1'b1)) u_brk (
    .clk(clk), .rst_n(rst_n), .set_i(brk_evt), .clr_i(any_rd), .q_o(brkd));

  p_ple_idle_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (!(bit_mid && lin_tx_active) && !rd_stat && !rd_rxd) |=> $stable(ple));
  p_brk_clr_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_stat && !brk_evt) |=> !brkd);
  p_brk_win_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (brk_evt && rd_rxd) |=> brkd);

endmodule

// File: rtl/lin_tx_flags.sv
module lin_tx_flags (
  input  logic clk,
  input  logic rst_n,
  input  logic wr_txd,
  input  logic tx_load,
  input  logic tx_done,
  output logic tdre,
  output logic txe
);

  lin_sticky_flag #(.RST_VAL(1'b1), .SET_WINS(1'b0)) u_tdre (
    .clk(clk), .rst_n(rst_n), .set_i(tx_load), .clr_i(wr_txd), .q_o(tdre));
  lin_sticky_flag #(.RST_VAL(1'b1), .SET_WINS(1'b0)) u_txe (
    .clk(clk), .rst_n(rst_n), .set_i(tx_done), .clr_i(tx_load), .q_o(txe));

  p_tdre_wr_r8: assert property (@(posedge clk) disable iff (!rst_n)
    wr_txd |=> !tdre);
  p_txe_load_r9: assert property (@(posedge clk) disable iff (!rst_n)
    tx_load |=> !txe);
  p_txe_done_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_done && !tx_load) |=> txe);

endmodule

// File: rtl/lin_uart_flags.sv
module lin_uart_flags
  import lin_flags_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rx_load,
  input  logic              rx_ferr,
  input  logic              abd_done,
  input  logic              abd_ovf,
  input  logic              brk_evt,
  input  logic              lin_tx_active,
  input  logic              bit_mid,
  input  logic              txd_bit,
  input  logic              rxd_bit,
  input  logic              wr_txd,
  input  logic              tx_load,
  input  logic              tx_done,
  input  logic              rd_stat,
  input  logic              rd_rxd,
  output logic [STAT_W-1:0] stat
);

  lin_stat_t flags;

  lin_rx_flags u_rx (
    .clk(clk), .rst_n(rst_n),
    .rx_load(rx_load), .rx_ferr(rx_ferr),
    .abd_done(abd_done), .abd_ovf(abd_ovf),
    .rd_stat(rd_stat), .rd_rxd(rd_rxd),
    .rda(flags.rda), .oe(flags.oe), .fe(flags.fe), .atb(flags.atb));

  lin_line_flags u_line (
    .clk(clk), .rst_n(rst_n),
    .lin_tx_active(lin_tx_active), .bit_mid(bit_mid),
    .txd_bit(txd_bit), .rxd_bit(rxd_bit), .brk_evt(brk_evt),
    .rd_stat(rd_stat), .rd_rxd(rd_rxd),
    .ple(flags.ple), .brkd(flags.brkd));

  lin_tx_flags u_tx (
    .clk(clk), .rst_n(rst_n),
    .wr_txd(wr_txd), .tx_load(tx_load), .tx_done(tx_done),
    .tdre(flags.tdre), .txe(flags.txe));

  assign stat = flags;

  p_rst_val_r10: assert property (@(posedge clk)
    !rst_n |=> (!rst_n || (stat == STAT_RST) || $past(rst_n)));
  p_rda_bit7_r10: assert property (@(posedge clk) disable iff (!rst_n)
    rx_load |=> stat[7]);

endmodule

// File: tb/lin_uart_flags_tb.sv
module lin_uart_flags_tb;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic rx_load = 0, rx_ferr = 0, abd_done = 0, abd_ovf = 0, brk_evt = 0;
  logic lin_tx_active = 0, bit_mid = 0, txd_bit = 0, rxd_bit = 0;
  logic wr_txd = 0, tx_load = 0, tx_done = 0, rd_stat = 0, rd_rxd = 0;
  logic [7:0] stat;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 0;
  logic [7:0] m;

  always #4 clk = ~clk;

  lin_uart_flags u_dut (
    .clk(clk), .rst_n(rst_n), .rx_load(rx_load), .rx_ferr(rx_ferr),
    .abd_done(abd_done), .abd_ovf(abd_ovf), .brk_evt(brk_evt),
    .lin_tx_active(lin_tx_active), .bit_mid(bit_mid),
    .txd_bit(txd_bit), .rxd_bit(rxd_bit), .wr_txd(wr_txd),
    .tx_load(tx_load), .tx_done(tx_done), .rd_stat(rd_stat),
    .rd_rxd(rd_rxd), .stat(stat));

  // bit -> requirement tag: 7 R1, 6 R5, 5 R2, 4 R4, 3 R6, 2 R8, 1 R9, 0 R3
  function automatic string req_of(int b);
    case (b)
      7: return "R1"; 6: return "R5"; 5: return "R2"; 4: return "R4";
      3: return "R6"; 2: return "R8"; 1: return "R9"; default: return "R3";
    endcase
  endfunction

  // behavioural reference model, written from the requirements
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) m <= 8'h06;                       // R10 reset value
    else begin
      bit rda, ple, oe, fe, bk, td, te, ab, anyrd;
      {rda, ple, oe, fe, bk, td, te, ab} = m;
      anyrd = rd_stat || rd_rxd;
      // R7: every receive-side and line flag below tests its set before its clear
      oe  = ((rx_load && rda && !rd_rxd) || abd_ovf) ? 1'b1 : (rd_rxd ? 1'b0 : oe);
      rda = rx_load ? 1'b1 : (rd_rxd ? 1'b0 : rda);
      fe  = rx_ferr ? 1'b1 : (rd_rxd ? 1'b0 : fe);
      ab  = (abd_done || abd_ovf) ? 1'b1 : (rd_stat ? 1'b0 : ab);
      ple = (lin_tx_active && bit_mid && (txd_bit != rxd_bit)) ? 1'b1 : (anyrd ? 1'b0 : ple);
      bk  = brk_evt ? 1'b1 : (anyrd ? 1'b0 : bk);
      td  = wr_txd ? 1'b0 : (tx_load ? 1'b1 : td);
      te  = tx_load ? 1'b0 : (tx_done ? 1'b1 : te);
      m <= {rda, ple, oe, fe, bk, td, te, ab};
    end
  end

  // compare on every falling edge
  always @(negedge clk) begin
    if (!done) begin
      n_chk++;
      if (stat !== m) begin
        int fb;
        fb = 0;
        for (int b = 0; b < 8; b++) if (stat[b] !== m[b]) fb = b;
        n_bad++;
        $display("[TB] FAIL %s (R10 bit %0d) stat=%02h expected=%02h at %0t",
                 req_of(fb), fb, stat, m, $time);
      end
    end
  end

  task automatic quiet();
    {rx_load, rx_ferr, abd_done, abd_ovf, brk_evt} = '0;
    {lin_tx_active, bit_mid, txd_bit, rxd_bit} = '0;
    {wr_txd, tx_load, tx_done, rd_stat, rd_rxd} = '0;
  endtask

  task automatic tick();
    @(negedge clk);
    quiet();
  endtask

  initial begin
    #20000000;
    if (!done) begin
      n_chk++; n_bad++;
      $display("[TB] FAIL watchdog expired");
      $display("[TB] %0d tests run, %0d failed", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    quiet();
    repeat (3) @(negedge clk);
    // R10: reset value checked by the negedge comparator while in reset
    rst_n = 1'b1;
    tick();
    // R1 set then clear; R2 overrun on second load
    rx_load = 1; tick();
    rx_load = 1; tick();
    rd_rxd = 1; tick();
    // R4 framing, R3 autobaud done / overflow, cleared by status read
    rx_ferr = 1; tick();
    abd_done = 1; tick();
    rd_stat = 1; tick();
    abd_ovf = 1; tick();
    rd_stat = 1; rd_rxd = 1; tick();
    // R5 mismatch outside the window is ignored
    txd_bit = 1; rxd_bit = 0; bit_mid = 1; tick();
    txd_bit = 1; rxd_bit = 0; lin_tx_active = 1; tick();
    txd_bit = 1; rxd_bit = 1; lin_tx_active = 1; bit_mid = 1; tick();
    txd_bit = 0; rxd_bit = 1; lin_tx_active = 1; bit_mid = 1; tick();
    rd_stat = 1; tick();
    // R6 break, cleared by receive data read
    brk_evt = 1; tick();
    rd_rxd = 1; tick();
    // R7 set together with clearing read ends at 1
    brk_evt = 1; rd_stat = 1; rx_load = 1; rd_rxd = 1; rx_ferr = 1; tick();
    lin_tx_active = 1; bit_mid = 1; txd_bit = 1; abd_done = 1; rd_stat = 1; tick();
    rd_stat = 1; rd_rxd = 1; tick();
    // R8 / R9 transmit path
    wr_txd = 1; tick();
    tx_load = 1; tick();
    wr_txd = 1; tx_load = 1; tick();
    tx_done = 1; tick();
    tx_done = 1; tx_load = 1; tick();
    tx_done = 1; tick();
    // random sparse strobes, compared each cycle
    for (int i = 0; i < 4000; i++) begin
      rx_load  = ($urandom_range(0, 5) == 0);
      rx_ferr  = ($urandom_range(0, 11) == 0);
      abd_done = ($urandom_range(0, 15) == 0);
      abd_ovf  = ($urandom_range(0, 23) == 0);
      brk_evt  = ($urandom_range(0, 15) == 0);
      lin_tx_active = ($urandom_range(0, 1) == 0);
      bit_mid  = ($urandom_range(0, 3) == 0);
      txd_bit  = 1'($urandom_range(0, 1));
      rxd_bit  = ($urandom_range(0, 7) == 0) ? ~txd_bit : txd_bit;
      wr_txd   = ($urandom_range(0, 5) == 0);
      tx_load  = ($urandom_range(0, 5) == 0);
      tx_done  = ($urandom_range(0, 5) == 0);
      rd_stat  = ($urandom_range(0, 6) == 0);
      rd_rxd   = ($urandom_range(0, 6) == 0);
      @(negedge clk);
    end
    quiet();
    @(negedge clk);
    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_chk, n_bad);
    $finish;
  end

endmodule